// File: doc/BRIEF.md
# Half-Table Distributed-Arithmetic FIR Filter

This block is a four-tap FIR filter with fixed coefficients. It contains no multipliers. Each sample is processed one bit at a time, least significant bit first. Every input bit is read as a signed digit of +1 or -1. The digit at the sign position is negated once more. With that encoding, a slice made of one bit from each tap selects a signed sum of all the coefficients. The folding trick is that two slices whose bits are complements of each other produce sums of equal size and opposite sign. Because of that, only 2^(NTAPS-1) sums are stored. The tap-0 bit then picks one of two paths: read the complemented address and use the value as it is, or read the plain address and negate the value.

The accumulator is loaded with a constant at the start of every output. The constant is minus the coefficient sum, and it cancels the bias that the ±1 encoding adds. The slice sums are kept at twice their true scale so that no half-unit is ever dropped, and the final shift right by one is exact.

To use the block, pulse `in_valid` with a new sample while the block is idle. The filtered result appears SW clock cycles later with a one-cycle `out_valid` pulse. A new sample may be offered in the cycle right after that pulse.

Top module: `obc_da_fir`

## Requirements
- R1: For every accepted sample, `out_data` is the exact two's-complement value of h0·x0 + h1·x1 + h2·x2 + h3·x3. Here x0 is the newest accepted sample, x3 is the oldest, and coefficient hk sits in bits [8k+7:8k] of `COEFS`.
- R2: `out_valid` rises exactly SW clock edges after the edge that accepted the sample. It stays low during the edges in between.
- R3: Each bit slice is served by a table of 2^(NTAPS-1) signed entries, addressed by the tap-1 to tap-3 bits. When the tap-0 bit is 1, the complemented address is read and the entry is used directly. When it is 0, the plain address is read and the entry is negated. Results are exact for every mix of tap-0 sign and magnitude.
- R4: The offset constant is applied once per output. All-zero history gives 0, all-ones samples (-1) give minus the coefficient sum, and most-negative samples (-128) give an exact result with no overflow.
- R5: An `in_valid` pulse that arrives while a result is being computed is ignored. It changes neither that result nor the sample history used by later results.
- R6: `out_valid` is high for exactly one clock cycle per accepted sample.
- R7: `out_data` keeps its value in every cycle where `out_valid` is low.
- R8: After reset, `out_valid` is 0, `out_data` is 0 and the whole sample history is zero.
- R9: A sample offered in the cycle right after an `out_valid` pulse is accepted. This sustains one result every SW+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | New sample strobe; takes effect only while the block is idle |
| in_sample | input | SW | Two's-complement input sample |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| out_data | output | SW+CW+$clog2(NTAPS) | Two's-complement filter output |

## Verification
The hardest case to reach is a strobe that lands in the middle of a bit-serial computation. The ports give no sign that the block is busy, and a correct design leaves no trace of the dropped sample. To get there, the stimulus raises `in_valid` with a distinctive value partway through a computation. It then checks that result and the next one, which would carry the dropped sample in its newest tap if it had been taken. Sign-fold coverage comes from an exhaustive sweep of every 8-bit value through the tap-0 position. That sweep is followed by runs of all-zero, all-ones, most-negative and alternating extreme samples, so that both table paths meet both signs at the sign-bit cycle.

// File: rtl/obc_fir_pkg.sv
package obc_fir_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } obc_phase_e;

  // signed width of a doubled slice sum of nt coefficients of cw bits
  function automatic int obc_slice_width(input int cw, input int nt);
    return cw + $clog2(nt) + 1;
  endfunction

  // accumulator width holding twice the filter output
  function automatic int obc_acc_width(input int sw, input int cw, input int nt);
    return sw + cw + $clog2(nt) + 1;
  endfunction

endpackage

// File: rtl/obc_fir_taps.sv
module obc_fir_taps #(
  parameter int NTAPS = 4,
  parameter int SW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [SW-1:0]     new_sample,
  output logic [NTAPS-1:0]  slice,
  output logic [SW-1:0]     newest
);
  // hist[0] is the most recently accepted sample
  logic [NTAPS-2:0][SW-1:0] hist;
  logic [NTAPS-1:0][SW-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist[0] <= '0;
      sreg[0] <= '0;
    end else if (load) begin
      hist[0] <= new_sample;
      sreg[0] <= new_sample;
    end else if (shift) begin
      sreg[0] <= sreg[0] >> 1;
    end
  end

  for (genvar k = 1; k < NTAPS; k++) begin : g_serial
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sreg[k] <= '0;
      else if (load)  sreg[k] <= hist[k-1];
      else if (shift) sreg[k] <= sreg[k] >> 1;
    end
    assign slice[k] = sreg[k][0];
  end

  for (genvar k = 1; k < NTAPS-1; k++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hist[k] <= '0;
      else if (load) hist[k] <= hist[k-1];
    end
  end

  assign slice[0] = sreg[0][0];
  assign newest   = hist[0];

endmodule

// File: rtl/obc_fir_rom.sv
module obc_fir_rom #(
  parameter int                      NTAPS = 4,
  parameter int                      CW    = 8,
  parameter int                      TW    = 11,
  parameter logic [NTAPS*CW-1:0]     COEFS = '0
) (
  input  logic [NTAPS-1:0]       slice,
  output logic signed [TW-1:0]   dsum
);
  localparam int ABITS = NTAPS - 1;
  localparam int DEPTH = 1 << ABITS;

  // entry a: h0 plus each higher tap, subtracted where its address bit is 1
  function automatic logic signed [TW-1:0] entry_f(input int a);
    logic signed [TW-1:0] acc;
    logic signed [TW-1:0] h;
    acc = TW'($signed(COEFS[CW-1:0]));
    for (int k = 1; k < NTAPS; k++) begin
      h = TW'($signed(COEFS[k*CW +: CW]));
      if (a[k-1]) acc = acc - h;
      else        acc = acc + h;
    end
    return acc;
  endfunction

  logic signed [TW-1:0] tbl [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_ent
    localparam logic signed [TW-1:0] ENT = entry_f(a);
    assign tbl[a] = ENT;
  end

  logic [ABITS-1:0]     addr;
  logic [ABITS-1:0]     fold_addr;
  logic signed [TW-1:0] fetched;

  assign addr      = slice[NTAPS-1:1];
  assign fold_addr = slice[0] ? ~addr : addr;
  assign fetched   = tbl[fold_addr];
  assign dsum      = slice[0] ? fetched : -fetched;

endmodule

// File: rtl/obc_fir_acc.sv
module obc_fir_acc #(
  parameter int                  SW   = 8,
  parameter int                  TW   = 11,
  parameter int                  AW   = 19,
  parameter int                  OW   = 18,
  parameter logic signed [AW-1:0] OFS = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         step,
  input  logic                         sign_cyc,
  input  logic                         last,
  input  logic [$clog2(SW)-1:0]        bitpos,
  input  logic signed [TW-1:0]         dsum,
  output logic                         res_valid,
  output logic signed [OW-1:0]         res_data
);
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] dext;
  logic signed [AW-1:0] contrib;
  logic signed [AW-1:0] acc_sum;

  assign dext    = AW'(dsum);
  assign contrib = sign_cyc ? -dext : dext;
  assign acc_sum = acc + (contrib <<< bitpos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= step && last;
      if (start)     acc <= OFS;
      else if (step) acc <= acc_sum;
      if (step && last) res_data <= acc_sum[AW-1:1];
    end
  end

endmodule

// File: rtl/obc_da_fir.sv
module obc_da_fir
  import obc_fir_pkg::*;
#(
  parameter int                  SW    = 8,
  parameter int                  CW    = 8,
  parameter int                  NTAPS = 4,
  parameter logic [NTAPS*CW-1:0] COEFS = 32'h8065_C717
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  input  logic [SW-1:0]                         in_sample,
  output logic                                  out_valid,
  output logic [SW+CW+$clog2(NTAPS)-1:0]        out_data
);
  localparam int TW   = obc_slice_width(CW, NTAPS);
  localparam int AW   = obc_acc_width(SW, CW, NTAPS);
  localparam int OW   = AW - 1;
  localparam int CNTW = $clog2(SW);

  function automatic logic signed [AW-1:0] offset_f();
    logic signed [AW-1:0] s;
    s = '0;
    for (int k = 0; k < NTAPS; k++) s = s - AW'($signed(COEFS[k*CW +: CW]));
    return s;
  endfunction

  function automatic int sumabs_f();
    int s;
    int h;
    s = 0;
    for (int k = 0; k < NTAPS; k++) begin
      h = int'($signed(COEFS[k*CW +: CW]));
      s = s + ((h < 0) ? -h : h);
    end
    return s;
  endfunction

  localparam logic signed [AW-1:0] OFS    = offset_f();
  localparam int                   SUMABS = sumabs_f();

  obc_phase_e            phase;
  logic [CNTW-1:0]       bitpos;
  logic                  take;
  logic                  step;
  logic                  last;
  logic                  sign_cyc;
  logic                  busy;
  logic [NTAPS-1:0]      slice;
  logic [SW-1:0]         newest;
  logic signed [TW-1:0]  dsum;
  logic signed [OW-1:0]  res_data;

  assign busy     = (phase == PH_RUN);
  assign take     = in_valid && !busy;
  assign step     = busy;
  assign sign_cyc = (bitpos == CNTW'(SW-1));
  assign last     = sign_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      bitpos <= '0;
    end else if (take) begin
      phase  <= PH_RUN;
      bitpos <= '0;
    end else if (step) begin
      bitpos <= bitpos + 1'b1;
      if (last) phase <= PH_IDLE;
    end
  end

  obc_fir_taps #(.NTAPS(NTAPS), .SW(SW)) u_taps (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (take),
    .shift      (step),
    .new_sample (in_sample),
    .slice      (slice),
    .newest     (newest)
  );

  obc_fir_rom #(.NTAPS(NTAPS), .CW(CW), .TW(TW), .COEFS(COEFS)) u_rom (
    .slice (slice),
    .dsum  (dsum)
  );

  obc_fir_acc #(.SW(SW), .TW(TW), .AW(AW), .OW(OW), .OFS(OFS)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (take),
    .step      (step),
    .sign_cyc  (sign_cyc),
    .last      (last),
    .bitpos    (bitpos),
    .dsum      (dsum),
    .res_valid (out_valid),
    .res_data  (res_data)
  );

  assign out_data = res_data;

endmodule

// File: rtl/obc_da_fir_chk.sv
module obc_da_fir_chk #(
  parameter int SW     = 8,
  parameter int OW     = 18,
  parameter int TW     = 11,
  parameter int SUMABS = 309
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 busy,
  input logic                 out_valid,
  input logic [OW-1:0]        out_data,
  input logic [SW-1:0]        newest,
  input logic signed [TW-1:0] dsum
);
  localparam int LW = $clog2(SW + 2) + 1;

  logic [LW-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  lat <= '0;
    else if (in_valid && !busy)  lat <= LW'(1);
    else if (out_valid)          lat <= '0;
    else if (lat != '0)          lat <= lat + 1'b1;
  end

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (lat == LW'(SW + 1)));                               // R2

  AST_BUSY_STROBE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && busy) |=> $stable(newest));                           // R5

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);                                         // R6

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));                                 // R7

  AST_SLICE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((dsum <= SUMABS) && (dsum >= -SUMABS)));                 // R3

endmodule

bind obc_da_fir obc_da_fir_chk #(
  .SW(SW), .OW(OW), .TW(TW), .SUMABS(SUMABS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .busy      (busy),
  .out_valid (out_valid),
  .out_data  (out_data),
  .newest    (newest),
  .dsum      (dsum)
);

// File: tb/obc_da_fir_tb.sv
`timescale 1ns/1ps
module obc_da_fir_tb;
  localparam int SW = 8;
  localparam int CW = 8;
  localparam int NT = 4;
  localparam int OW = SW + CW + $clog2(NT);
  localparam logic [NT*CW-1:0] COEFS = {8'sh80, 8'sh65, 8'shC7, 8'sh17};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [SW-1:0] in_sample = '0;
  logic          out_valid;
  logic [OW-1:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  int h [NT] = '{23, -57, 101, -128};
  int xr [NT] = '{0, 0, 0, 0};

  always #5 clk = ~clk;

  obc_da_fir #(.SW(SW), .CW(CW), .NTAPS(NT), .COEFS(COEFS)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_out();
    int s = 0;
    for (int k = 0; k < NT; k++) s += h[k] * xr[k];
    return s;
  endfunction

  // offers s at a negedge, optionally strobes a stray sample mid-computation,
  // and checks the result timing and value
  task automatic send(input int s, input bit stray, input string req);
    bit early;
    int exp;
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = s[SW-1:0];
    for (int k = NT - 1; k > 0; k--) xr[k] = xr[k-1];
    xr[0] = s;
    exp = ref_out();
    early = 1'b0;
    @(negedge clk);
    for (int i = 1; i <= SW; i++) begin
      if (out_valid) early = 1'b1;
      if (stray && i == 3) begin
        in_valid  = 1'b1;
        in_sample = 8'h5A;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(!early && out_valid, "R2 latency", {31'd0, out_valid}, 1);
    check($signed(out_data) == exp, req, $signed(out_data), exp);
  endtask

  task automatic idle_hold(input int n);
    logic [OW-1:0] held;
    held = out_data;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(!out_valid, "R6 single pulse", {31'd0, out_valid}, 0);
      check(out_data == held, "R7 hold", $signed(out_data), $signed(held));
    end
  endtask

  initial begin
    #(100000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 reset valid", {31'd0, out_valid}, 0);
    check(out_data == '0, "R8 reset data", $signed(out_data), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // first results see zero history in older taps
    send(100, 1'b0, "R8 zero history");
    send(-3, 1'b0, "R8 zero history");

    // exhaustive sweep of every sample value through all taps, back to back
    for (int s = -128; s < 128; s++) send(s, 1'b0, "R1 sweep");
    send(5, 1'b0, "R9 back to back");

    // offset and extreme patterns
    for (int i = 0; i < NT; i++) send(0, 1'b0, "R4 all zero");
    for (int i = 0; i < NT; i++) send(-1, 1'b0, "R4 all ones");
    for (int i = 0; i < NT; i++) send(-128, 1'b0, "R4 most negative");
    for (int i = 0; i < NT; i++) send(127, 1'b0, "R3 max positive");
    for (int i = 0; i < 2 * NT; i++) send((i % 2) ? 127 : -128, 1'b0, "R3 sign fold alt");
    for (int i = 0; i < 2 * NT; i++) send((i % 2) ? -1 : 64, 1'b0, "R3 sign fold mix");

    // stray strobe while busy must leave result and history untouched
    send(77, 1'b1, "R5 stray ignored");
    send(-90, 1'b0, "R5 history intact");
    send(33, 1'b1, "R5 stray ignored");
    send(12, 1'b0, "R5 history intact");

    idle_hold(6);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule